// File: doc/BRIEF.md
# Serial DAC Command Frame Controller

This block sits on the host side of a multi-channel serial digital-to-analog converter. It accepts high-level requests over a valid/ready handshake and turns each one into a 24-bit command frame. A request can load a new code into a channel, power a channel down, or power a channel back up. The frame is shifted out over a three-wire SPI master link made of chip select, serial clock and data out. The resolution (8, 10 or 12 bits), the channel count (2, 4 or 8), the serial clock rate and the choice of reference are all parameters.

After reset the controller sends one reference-select frame before it accepts any request. It checks every request before anything goes on the wire. A bad channel number, a reserved operation or an out-of-range code raises a one-cycle error pulse, and no frame is sent. The controller also keeps a mask with one bit per channel that records which channels are powered down.

The control FSM has four states:

- `CT_BOOT` issues the reference frame and moves to `CT_BOOT_WAIT`.
- `CT_BOOT_WAIT` returns to `CT_IDLE` when the shifter reports done.
- `CT_IDLE` moves to `CT_XFER` when a request is accepted and passes its checks. It stays in `CT_IDLE` when a request is rejected.
- `CT_XFER` returns to `CT_IDLE` on shifter done.

The shifter FSM has four states:

- `SH_IDLE` moves to `SH_LOW` on start.
- `SH_LOW` moves to `SH_HIGH` after one half period.
- `SH_HIGH` moves back to `SH_LOW` after one half period, or to `SH_HOLD` after the last bit.
- `SH_HOLD` returns to `SH_IDLE` after one half period and raises done.

Top module: `dac_frame_ctrl`

## Requirements
- R1: A frame is 24 bits, sent MSB first. Bits 23:20 carry the command, bits 19:16 the channel address and bits 15:0 the data field. The serial clock idles low, data changes only while the clock is low, and the receiver samples on the rising edge.
- R2: A write request (op 2'b00) sends command 0x3 with the channel in the address field. The code is left-justified in the data field, shifted up by 16 minus the resolution, and the low bits are zero.
- R3: A power-down request (op 2'b01) sends command 0x4 with the channel address and zero data, and sets that channel's bit in `pd_mask`.
- R4: A power-up request (op 2'b10) sends command 0x1 with the channel address and zero data, and clears that channel's bit. An accepted write to a channel also clears its bit.
- R5: After reset the first frame is a reference select: command 0x6 for the internal reference, or 0x7 when `EXT_REF` is 1, with address and data zero. `req_ready` stays low until that frame ends.
- R6: A write whose code is negative (bit 16 set) or not below 2^resolution raises `req_err` for exactly the cycle after the handshake. No frame is sent and `pd_mask` is unchanged.
- R7: A request whose channel is at or above the channel count, or whose op is 2'b11, is rejected in the same way: error pulse, no frame, mask unchanged.
- R8: Chip select stays low for exactly 24 rising clock edges per frame, and `busy` is high exactly while chip select is low.
- R9: During and right after reset, chip select is high, the serial clock is low, `pd_mask` is all zero, and `req_err` and `req_ready` are low.
- R10: `req_ready` is low while a frame is in flight. A request held valid across a frame is taken only after the frame ends, and back-to-back requests each produce their own frame in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_op | input | 2 | 00 write, 01 power-down, 10 power-up, 11 reserved |
| req_chan | input | 4 | Target channel |
| req_code | input | 17 | Signed code for writes (bit 16 is the sign) |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| busy | output | 1 | A frame is on the wire |
| pd_mask | output | NUM_CH | Power-down status, one bit per channel |
| spi_csn | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |

## Verification
Two events can land in the same cycle:

- a shifter finishing a frame, which releases chip select and reopens `req_ready`;
- the acceptance of a request that the host has been holding valid throughout that frame.

The bench provokes this by issuing a second request immediately after the first is accepted and holding it until it is taken. It then checks that the frames arrive in order with correct contents and 24 clock edges each. A rejected request is placed directly after a good frame, to confirm that the error pulse and the unchanged chip select appear without a stray frame.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

    localparam int FRAME_W = 24;
    localparam int DATA_W  = 16;
    localparam int CODE_W  = 17;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_PDOWN = 2'b01,
        OP_PUP   = 2'b10,
        OP_RSVD  = 2'b11
    } req_op_e;

    typedef enum logic [3:0] {
        CMD_UPDATE_N    = 4'h1,
        CMD_WRITE_UPD_N = 4'h3,
        CMD_PDOWN_N     = 4'h4,
        CMD_REF_INT     = 4'h6,
        CMD_REF_EXT     = 4'h7
    } dac_cmd_e;

    typedef enum logic [1:0] {
        CT_BOOT,
        CT_BOOT_WAIT,
        CT_IDLE,
        CT_XFER
    } ctrl_state_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_HOLD
    } shift_state_e;

    typedef struct packed {
        logic [3:0]        cmd;
        logic [3:0]        addr;
        logic [DATA_W-1:0] data;
    } frame_t;

endpackage

// File: rtl/dac_req_decode.sv
module dac_req_decode
    import dac_frame_pkg::*;
#(
    parameter int RES_BITS = 12,
    parameter int NUM_CH   = 8
) (
    input  logic [1:0]        op,
    input  logic [3:0]        chan,
    input  logic [CODE_W-1:0] code,
    output frame_t            frame,
    output logic              reject,
    output logic              pd_set,
    output logic              pd_clr
);

    localparam int              SHIFT    = DATA_W - RES_BITS;
    localparam logic [4:0]      CH_LIM   = 5'(NUM_CH);
    localparam logic [DATA_W-1:0] CODE_MAX = DATA_W'((1 << RES_BITS) - 1);

    logic chan_bad;
    logic code_bad;

    assign chan_bad = ({1'b0, chan} >= CH_LIM);
    assign code_bad = code[CODE_W-1] || (code[DATA_W-1:0] > CODE_MAX);

    always_comb begin
        frame.cmd  = CMD_WRITE_UPD_N;
        frame.addr = chan;
        frame.data = '0;
        reject     = chan_bad;
        pd_set     = 1'b0;
        pd_clr     = 1'b0;
        unique case (op)
            OP_WRITE: begin
                frame.cmd  = CMD_WRITE_UPD_N;
                frame.data = code[DATA_W-1:0] << SHIFT;
                reject     = chan_bad || code_bad;
                pd_clr     = 1'b1;
            end
            OP_PDOWN: begin
                frame.cmd = CMD_PDOWN_N;
                pd_set    = 1'b1;
            end
            OP_PUP: begin
                frame.cmd = CMD_UPDATE_N;
                pd_clr    = 1'b1;
            end
            default: begin
                reject = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dac_pd_track.sv
module dac_pd_track #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              set_bit,
    input  logic [3:0]        chan,
    output logic [NUM_CH-1:0] mask
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[i] <= 1'b0;
            end else if (upd_en && (chan == 4'(i))) begin
                mask[i] <= set_bit;
            end
        end
    end

    // Mask holds when no accepted update is present (R6, R7)
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(mask));

endmodule

// File: rtl/dac_spi_shift.sv
module dac_spi_shift
    import dac_frame_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               busy,
    output logic               done,
    output logic               csn,
    output logic               sclk,
    output logic               mosi
);

    localparam int             CNT_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);
    localparam logic [4:0]     BIT_TOP  = 5'(FRAME_W - 1);

    shift_state_e       state, state_n;
    logic [FRAME_W-1:0] shreg;
    logic [4:0]         bitcnt;
    logic [CNT_W-1:0]   cnt;
    logic               half_end;
    logic               last_bit;

    assign half_end = (cnt == CNT_LAST);
    assign last_bit = (bitcnt == 5'd0);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SH_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            cnt    <= '0;
        end else begin
            state <= state_n;
            unique case (state)
                SH_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        shreg  <= frame_in;
                        bitcnt <= BIT_TOP;
                    end
                end
                SH_LOW, SH_HOLD: begin
                    cnt <= half_end ? '0 : cnt + 1'b1;
                end
                SH_HIGH: begin
                    if (half_end) begin
                        cnt <= '0;
                        if (!last_bit) begin
                            shreg  <= {shreg[FRAME_W-2:0], 1'b0};
                            bitcnt <= bitcnt - 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            SH_IDLE: if (start)    state_n = SH_LOW;
            SH_LOW:  if (half_end) state_n = SH_HIGH;
            SH_HIGH: if (half_end) state_n = last_bit ? SH_HOLD : SH_LOW;
            SH_HOLD: if (half_end) state_n = SH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        csn  = (state == SH_IDLE);
        sclk = (state == SH_HIGH);
        busy = (state != SH_IDLE);
        done = (state == SH_HOLD) && half_end;
        mosi = shreg[FRAME_W-1];
    end

    // checker: count rising clock edges per frame
    logic [5:0] rise_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt <= '0;
        end else if (state == SH_IDLE) begin
            rise_cnt <= '0;
        end else if (state == SH_LOW && half_end) begin
            rise_cnt <= rise_cnt + 1'b1;
        end
    end

    p_frame_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rise_cnt == 6'd24));

    p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == SH_IDLE));

    p_mosi_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
    import dac_frame_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter int NUM_CH    = 8,
    parameter int SCLK_HALF = 2,
    parameter bit EXT_REF   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [3:0]        req_chan,
    input  logic [16:0]       req_code,
    output logic              req_err,
    output logic              busy,
    output logic [NUM_CH-1:0] pd_mask,
    output logic              spi_csn,
    output logic              spi_sclk,
    output logic              spi_mosi
);

    localparam frame_t BOOT_FRAME = '{
        cmd:  EXT_REF ? CMD_REF_EXT : CMD_REF_INT,
        addr: 4'h0,
        data: '0
    };

    ctrl_state_e st, st_n;
    frame_t      dec_frame;
    frame_t      sh_frame;
    logic        rej, pd_set, pd_clr;
    logic        fire, sh_start, sh_busy, sh_done;
    logic        err_q;
    logic        upd_en;

    dac_req_decode #(
        .RES_BITS (RES_BITS),
        .NUM_CH   (NUM_CH)
    ) u_decode (
        .op     (req_op),
        .chan   (req_chan),
        .code   (req_code),
        .frame  (dec_frame),
        .reject (rej),
        .pd_set (pd_set),
        .pd_clr (pd_clr)
    );

    dac_spi_shift #(
        .HALF_CYC (SCLK_HALF)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sh_start),
        .frame_in (sh_frame),
        .busy     (sh_busy),
        .done     (sh_done),
        .csn      (spi_csn),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi)
    );

    dac_pd_track #(
        .NUM_CH (NUM_CH)
    ) u_pd (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .set_bit (pd_set),
        .chan    (req_chan),
        .mask    (pd_mask)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= CT_BOOT;
            err_q <= 1'b0;
        end else begin
            st    <= st_n;
            err_q <= fire && rej;
        end
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            CT_BOOT:      st_n = CT_BOOT_WAIT;
            CT_BOOT_WAIT: if (sh_done) st_n = CT_IDLE;
            CT_IDLE:      if (fire && !rej) st_n = CT_XFER;
            CT_XFER:      if (sh_done) st_n = CT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (st == CT_IDLE) && !sh_busy;
        fire      = req_valid && req_ready;
        sh_start  = (st == CT_BOOT) || (fire && !rej);
        sh_frame  = (st == CT_BOOT) ? BOOT_FRAME : dec_frame;
        upd_en    = fire && !rej && (pd_set || pd_clr);
        busy      = sh_busy;
        req_err   = err_q;
    end

    p_err_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid && req_ready));

    p_no_frame_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> spi_csn);

    p_ready_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

    p_csn_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !spi_csn);

endmodule

// File: tb/test_dac_frame_ctrl.sv
module test_dac_frame_ctrl;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [3:0]  req_chan = 4'h0;
    logic [16:0] req_code = '0;
    logic        req_err;
    logic        busy;
    logic [NCH-1:0] pd_mask;
    logic        spi_csn, spi_sclk, spi_mosi;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dac_frame_ctrl #(
        .RES_BITS  (12),
        .NUM_CH    (NCH),
        .SCLK_HALF (2),
        .EXT_REF   (1'b0)
    ) i_dac_frame_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_chan  (req_chan),
        .req_code  (req_code),
        .req_err   (req_err),
        .busy      (busy),
        .pd_mask   (pd_mask),
        .spi_csn   (spi_csn),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi)
    );

    // serial monitor
    bit          mon_en = 1'b0;
    logic [23:0] mon_sh = '0;
    int          mon_edges = 0;
    int          frames = 0;
    logic [23:0] flog [0:31];
    int          elog [0:31];

    always @(posedge spi_sclk or posedge spi_csn) begin
        if (spi_csn === 1'b1) begin
            if (mon_en) begin
                flog[frames % 32] = mon_sh;
                elog[frames % 32] = mon_edges;
                frames = frames + 1;
            end
            mon_edges = 0;
        end else begin
            mon_sh    = {mon_sh[22:0], spi_mosi};
            mon_edges = mon_edges + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_quiet();
        int n = 0;
        @(negedge clk);
        while ((busy || !req_ready) && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] ch, input int code,
                         output bit err_seen);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_chan  = ch;
        req_code  = code[16:0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        err_seen  = req_err;
    endtask

    task automatic good_frame(input string req, input logic [1:0] op, input logic [3:0] ch,
                              input int code, input logic [23:0] exp);
        bit e;
        int f0 = frames;
        issue(op, ch, code, e);
        check(!e, req, "no error", 32'(e), 0);
        wait_quiet();
        check(frames == f0 + 1, req, "frame count", frames, f0 + 1);
        check(flog[f0 % 32] == exp, req, "frame content", flog[f0 % 32], exp);
        check(elog[f0 % 32] == 24, "R8", "clock edges", elog[f0 % 32], 24);
    endtask

    task automatic bad_req(input string req, input logic [1:0] op, input logic [3:0] ch,
                           input int code);
        bit e;
        int f0 = frames;
        logic [NCH-1:0] m0 = pd_mask;
        issue(op, ch, code, e);
        check(e, req, "error pulse", 32'(e), 1);
        @(negedge clk);
        check(!req_err, req, "error one cycle", 32'(req_err), 0);
        repeat (20) @(negedge clk);
        check(frames == f0, req, "no frame", frames, f0);
        check(pd_mask == m0, req, "mask unchanged", 32'(pd_mask), 32'(m0));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(spi_csn === 1'b1, "R9", "csn in reset", 32'(spi_csn), 1);
        check(spi_sclk === 1'b0, "R9", "sclk in reset", 32'(spi_sclk), 0);
        check(pd_mask === '0, "R9", "mask in reset", 32'(pd_mask), 0);
        check(req_err === 1'b0, "R9", "err in reset", 32'(req_err), 0);
        check(req_ready === 1'b0, "R9", "ready in reset", 32'(req_ready), 0);
    endtask

    task automatic t_boot();
        mon_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b0, "R5", "ready during boot", 32'(req_ready), 0);
        check(busy == 1'b1, "R8", "busy during boot", 32'(busy), 1);
        wait_quiet();
        check(frames == 1, "R5", "boot frame count", frames, 1);
        check(flog[0] == 24'h600000, "R5", "boot frame", flog[0], 24'h600000);
        check(elog[0] == 24, "R8", "boot edges", elog[0], 24);
    endtask

    task automatic t_writes();
        good_frame("R2", 2'b00, 4'd2, 12'hABC, 24'h32ABC0);
        good_frame("R2", 2'b00, 4'd0, 4095, 24'h30FFF0);
        good_frame("R1", 2'b00, 4'd3, 0, 24'h330000);
        good_frame("R1", 2'b00, 4'd1, 12'h801, 24'h318010);
    endtask

    task automatic t_power();
        good_frame("R3", 2'b01, 4'd1, 0, 24'h410000);
        check(pd_mask == 4'b0010, "R3", "mask set", 32'(pd_mask), 4'b0010);
        good_frame("R3", 2'b01, 4'd3, 0, 24'h430000);
        check(pd_mask == 4'b1010, "R3", "mask set 2", 32'(pd_mask), 4'b1010);
        good_frame("R4", 2'b10, 4'd1, 0, 24'h110000);
        check(pd_mask == 4'b1000, "R4", "mask clear", 32'(pd_mask), 4'b1000);
        good_frame("R4", 2'b00, 4'd3, 5, 24'h330050);
        check(pd_mask == 4'b0000, "R4", "write clears", 32'(pd_mask), 0);
        good_frame("R3", 2'b01, 4'd0, 0, 24'h400000);
    endtask

    task automatic t_rejects();
        bad_req("R6", 2'b00, 4'd1, 4096);
        bad_req("R6", 2'b00, 4'd1, -1);
        bad_req("R7", 2'b01, 4'd4, 0);
        bad_req("R7", 2'b00, 4'd15, 7);
        bad_req("R7", 2'b11, 4'd0, 0);
        check(pd_mask == 4'b0001, "R7", "mask after rejects", 32'(pd_mask), 4'b0001);
    endtask

    task automatic t_busy();
        bit e;
        issue(2'b00, 4'd2, 1, e);
        repeat (30) @(negedge clk);
        check(busy == 1'b1, "R8", "busy mid frame", 32'(busy), 1);
        check(spi_csn == 1'b0, "R8", "csn mid frame", 32'(spi_csn), 0);
        check(req_ready == 1'b0, "R10", "ready mid frame", 32'(req_ready), 0);
        wait_quiet();
        check(spi_csn == 1'b1, "R8", "csn after frame", 32'(spi_csn), 1);
    endtask

    task automatic t_b2b();
        bit e1, e2;
        int f0 = frames;
        issue(2'b00, 4'd1, 12'h123, e1);
        issue(2'b01, 4'd2, 0, e2);
        wait_quiet();
        check(frames == f0 + 2, "R10", "b2b frame count", frames, f0 + 2);
        check(flog[f0 % 32] == 24'h311230, "R10", "b2b first", flog[f0 % 32], 24'h311230);
        check(flog[(f0 + 1) % 32] == 24'h420000, "R10", "b2b second",
              flog[(f0 + 1) % 32], 24'h420000);
        check(elog[(f0 + 1) % 32] == 24, "R8", "b2b edges", elog[(f0 + 1) % 32], 24);
        check(pd_mask == 4'b0101, "R10", "b2b mask", 32'(pd_mask), 4'b0101);
        bad_req("R6", 2'b00, 4'd0, 70000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R8: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_boot();
        t_writes();
        t_power();
        t_rejects();
        t_busy();
        t_b2b();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule